// File: doc/BRIEF.md
# Per-Connection Cell Pacing Scheduler

This block decides which of a small set of transmit connections sends the next fixed-size cell onto a link. Software queues work for a connection as a burst: it presents a connection index together with a number of cells on the post port, and the block adds that number to the connection's pending-cell counter. The block then releases the burst one cell at a time. Each connection has its own programmable spacing interval, so several connections can drain at different rates simultaneously and none exceeds its agreed peak rate.

A connection can instead be marked low-delay. Such a connection ignores its spacing interval and takes strict priority over every paced connection, so its cells overtake paced traffic rather than queue behind it. Each clock cycle is one link cell slot. The result is a stream of connection identifiers offered to a downstream segmentation engine over a valid/ready handshake. A grant that has been offered is held until the engine accepts it, and the bookkeeping for that cell (counter decrement, interval reload, round-robin pointer move) happens only on acceptance.

Top module: `pace_sched`

## Requirements
- R1: After reset no grant is offered, all pending counters, interval timers and both round-robin pointers are zero, every interval is 0 and every low-delay flag is clear; a connection with interval 0 then drains one cell per cycle.
- R2: A post adds postCount to the connection's pending counter (saturating at all ones), each accepted grant removes one cell, a connection with a zero counter is never offered, and posting to a connection while it drains adds to what remains.
- R3: While grantValid is high and grantReady is low, grantValid stays high and grantId does not change, and no cell is consumed.
- R4: For a paced connection with interval V, two accepted grants are at least max(V,1) cycles apart, and exactly max(V,1) cycles apart when it is the only active connection and grantReady stays high.
- R5: Intervals are independent per connection, so two paced connections with different intervals each keep their own spacing while draining concurrently.
- R6: A low-delay connection ignores its interval and can be granted in consecutive cycles.
- R7: Whenever a new grant is chosen and any low-delay connection has pending cells, a low-delay connection is chosen, even if paced connections are eligible.
- R8: Among eligible paced connections the choice is round-robin, searching upward (wrapping) from the index after the last accepted paced grant; after reset that search starts at connection 1.
- R9: Low-delay connections use their own round-robin pointer with the same rule, which moves only on accepted low-delay grants and leaves the paced pointer untouched, and vice versa.
- R10: At most one grant is accepted per cycle, and accepted grants may occur in back-to-back cycles.
- R11: A configuration write (cfgWe high) sets the interval and the low-delay flag of connection cfgIdx, taking effect for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one link cell slot |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | ID_W (3) | Connection written by cfgWe |
| cfgInterval | input | IVAL_W (16) | Spacing interval in cell slots |
| cfgLowDelay | input | 1 | Low-delay flag for the connection |
| postValid | input | 1 | Burst post strobe |
| postIdx | input | ID_W (3) | Connection receiving the burst |
| postCount | input | CNT_W (16) | Number of cells in the burst |
| grantValid | output | 1 | A grant is offered |
| grantReady | input | 1 | Downstream accepts the offered grant |
| grantId | output | ID_W (3) | Connection identifier of the offered grant |

## Verification
The assertions assume that software never posts so many cells that a counter would have to saturate, and that a configuration change does not alter a connection's low-delay flag while that connection's grant is being held; the stimulus keeps bursts to a few cells and only reconfigures connections that have nothing pending. Under those conditions the checks on a held grant, on pacing gaps and on low-delay precedence hold at every edge. The bench sweeps every connection through a distinct interval, then builds fixed orderings by holding grantReady low while posting, so that the expected identifier sequence and cycle gaps follow arithmetically from the round-robin and priority rules.

// File: rtl/pace_pkg.sv
package pace_pkg;
  // Control-to-datapath strobes for an accepted grant.
  typedef struct packed {
    logic fire;     // grant accepted this cycle
    logic fireLow;  // accepted grant belongs to the low-delay class
  } pace_strobe_t;
endpackage

// File: rtl/pace_rr.sv
module pace_rr #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] last,
  output logic           found,
  output logic [IDW-1:0] pick
);
  // Search upward from the entry after 'last', wrapping once.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[(int'(last) + k) % N]) begin
        found = 1'b1;
        pick  = IDW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/pace_dp.sv
module pace_dp
  import pace_pkg::*;
#(
  parameter int N   = 8,
  parameter int IVW = 16,
  parameter int CW  = 16,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [IDW-1:0] cfgIdx,
  input  logic [IVW-1:0] cfgInterval,
  input  logic           cfgLowDelay,
  input  logic           postValid,
  input  logic [IDW-1:0] postIdx,
  input  logic [CW-1:0]  postCount,
  input  pace_strobe_t   strobe,
  input  logic [IDW-1:0] fireId,
  output logic [N-1:0]   pacedReq,
  output logic [N-1:0]   lowReq
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_conn
    logic [IVW-1:0] ivalQ;
    logic           lowQ;
    logic [CW-1:0]  cntQ;
    logic [IVW-1:0] tmrQ;
    logic           addHit;
    logic           decHit;
    logic [CW:0]    sumW;

    assign addHit = postValid && (postIdx == IDW'(i));
    assign decHit = strobe.fire && (fireId == IDW'(i));

    always_comb begin
      sumW = {1'b0, cntQ} + (addHit ? {1'b0, postCount} : '0);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ivalQ <= '0;
        lowQ  <= 1'b0;
        cntQ  <= '0;
        tmrQ  <= '0;
      end else begin
        if (cfgWe && (cfgIdx == IDW'(i))) begin
          ivalQ <= cfgInterval;
          lowQ  <= cfgLowDelay;
        end
        cntQ <= (sumW[CW] ? CNT_MAX : sumW[CW-1:0]) - CW'(decHit);
        if (decHit) begin
          tmrQ <= (ivalQ > IVW'(1)) ? ivalQ - IVW'(1) : '0;
        end else if (tmrQ != '0) begin
          tmrQ <= tmrQ - IVW'(1);
        end
      end
    end

    assign pacedReq[i] = (cntQ != '0) && (tmrQ == '0) && !lowQ;
    assign lowReq[i]   = (cntQ != '0) && lowQ;

    // R2: an accepted grant always consumes a real pending cell.
    p_no_empty_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
      decHit |-> (cntQ != '0));

    // R4: a paced grant is accepted only once its spacing has elapsed.
    p_pace_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
      (decHit && !strobe.fireLow) |-> (tmrQ == '0));
  end
endmodule

// File: rtl/pace_ctrl.sv
module pace_ctrl
  import pace_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   pacedReq,
  input  logic [N-1:0]   lowReq,
  input  logic           grantReady,
  output logic           grantValid,
  output logic [IDW-1:0] grantId,
  output pace_strobe_t   strobe
);
  localparam int NCLS = 2;  // class 0 paced, class 1 low-delay

  logic [NCLS-1:0][N-1:0]   classReq;
  logic [NCLS-1:0][IDW-1:0] ptrQ;
  logic [NCLS-1:0]          found;
  logic [NCLS-1:0][IDW-1:0] pickIdx;

  logic           heldQ;
  logic           heldLowQ;
  logic [IDW-1:0] heldIdQ;
  logic           pickLow;
  logic [IDW-1:0] pickId;
  logic           grantLow;
  logic           fire;

  assign classReq[0] = pacedReq;
  assign classReq[1] = lowReq;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    pace_rr #(.N(N), .IDW(IDW)) u_rr (
      .req  (classReq[g]),
      .last (ptrQ[g]),
      .found(found[g]),
      .pick (pickIdx[g])
    );
  end

  // Low-delay class wins whenever it has any candidate.
  assign pickLow    = found[1];
  assign pickId     = found[1] ? pickIdx[1] : pickIdx[0];
  assign grantValid = heldQ | found[0] | found[1];
  assign grantId    = heldQ ? heldIdQ : pickId;
  assign grantLow   = heldQ ? heldLowQ : pickLow;
  assign fire       = grantValid && grantReady;

  assign strobe.fire    = fire;
  assign strobe.fireLow = grantLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ    <= 1'b0;
      heldLowQ <= 1'b0;
      heldIdQ  <= '0;
      ptrQ     <= '0;
    end else begin
      if (fire) begin
        heldQ <= 1'b0;
        ptrQ[grantLow] <= grantId;
      end else if (grantValid && !heldQ) begin
        heldQ    <= 1'b1;
        heldIdQ  <= pickId;
        heldLowQ <= pickLow;
      end
    end
  end

  // R3: an offered grant stays put until it is accepted.
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantReady) |=> (grantValid && grantId == $past(grantId)));

  // R7: a fresh choice goes to low-delay work whenever there is any.
  p_low_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !heldQ && (|lowReq)) |-> grantLow);

  // R2: a fresh offer exists only when some connection has eligible work.
  p_valid_has_work_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !heldQ) |-> (|(pacedReq | lowReq)));
endmodule

// File: rtl/pace_sched.sv
module pace_sched
  import pace_pkg::*;
#(
  parameter int N_CONN = 8,
  parameter int IVAL_W = 16,
  parameter int CNT_W  = 16,
  localparam int ID_W  = $clog2(N_CONN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ID_W-1:0]   cfgIdx,
  input  logic [IVAL_W-1:0] cfgInterval,
  input  logic              cfgLowDelay,
  input  logic              postValid,
  input  logic [ID_W-1:0]   postIdx,
  input  logic [CNT_W-1:0]  postCount,
  output logic              grantValid,
  input  logic              grantReady,
  output logic [ID_W-1:0]   grantId
);
  pace_strobe_t      strobe;
  logic [N_CONN-1:0] pacedReq;
  logic [N_CONN-1:0] lowReq;

  pace_dp #(.N(N_CONN), .IVW(IVAL_W), .CW(CNT_W), .IDW(ID_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgIdx     (cfgIdx),
    .cfgInterval(cfgInterval),
    .cfgLowDelay(cfgLowDelay),
    .postValid  (postValid),
    .postIdx    (postIdx),
    .postCount  (postCount),
    .strobe     (strobe),
    .fireId     (grantId),
    .pacedReq   (pacedReq),
    .lowReq     (lowReq)
  );

  pace_ctrl #(.N(N_CONN), .IDW(ID_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pacedReq  (pacedReq),
    .lowReq    (lowReq),
    .grantReady(grantReady),
    .grantValid(grantValid),
    .grantId   (grantId),
    .strobe    (strobe)
  );
endmodule

// File: tb/pace_sched_bench.sv
module pace_sched_bench;
  localparam int N = 8;
  localparam int IW = 16;
  localparam int CW = 16;
  localparam int IDW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic           rstN = 1'b0;
  logic           cfgWe = 1'b0;
  logic [IDW-1:0] cfgIdx = '0;
  logic [IW-1:0]  cfgInterval = '0;
  logic           cfgLowDelay = 1'b0;
  logic           postValid = 1'b0;
  logic [IDW-1:0] postIdx = '0;
  logic [CW-1:0]  postCount = '0;
  logic           grantValid;
  logic           grantReady = 1'b0;
  logic [IDW-1:0] grantId;

  pace_sched #(.N_CONN(N), .IVAL_W(IW), .CNT_W(CW)) u_pace_sched (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgInterval(cfgInterval), .cfgLowDelay(cfgLowDelay),
    .postValid(postValid), .postIdx(postIdx), .postCount(postCount),
    .grantValid(grantValid), .grantReady(grantReady), .grantId(grantId)
  );

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  int logN = 0;
  int logId [512];
  int logCyc [512];
  bit finished = 0;

  // Record every accepted grant with the cycle it was accepted in.
  always @(posedge clk) begin
    if (rstN && grantValid && grantReady && logN < 512) begin
      logId[logN] = int'(grantId);
      logCyc[logN] = cyc;
      logN = logN + 1;
    end
    cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0; cfgWe = 1'b0; postValid = 1'b0; grantReady = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    logN = 0;
  endtask

  task automatic setCfg(input int idx, input int iv, input bit low);
    cfgWe = 1'b1; cfgIdx = IDW'(idx); cfgInterval = IW'(iv); cfgLowDelay = low;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic post(input int idx, input int cnt);
    postValid = 1'b1; postIdx = IDW'(idx); postCount = CW'(cnt);
    @(negedge clk);
    postValid = 1'b0;
  endtask

  task automatic expectIds(input string req, input int n, input int e [8]);
    chk(logN == n, req, logN, n);
    for (int k = 0; k < n; k++) chk(logId[k] == e[k], req, logId[k], e[k]);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    int e [8];
    int cntA;
    int cntB;
    int lastA;
    int lastB;

    doReset();
    // R1: nothing offered after reset, even with ready high.
    chk(grantValid == 1'b0, "R1", int'(grantValid), 0);
    grantReady = 1'b1;
    idle(5);
    chk(grantValid == 1'b0 && logN == 0, "R1", logN, 0);

    // R1/R10: reset interval 0 drains one cell every cycle.
    post(2, 3);
    idle(10);
    chk(logN == 3, "R1", logN, 3);
    for (int k = 1; k < 3; k++) chk(logCyc[k] - logCyc[k-1] == 1, "R10", logCyc[k] - logCyc[k-1], 1);

    // R4/R11/R2: each connection gets its own interval, equal to its index.
    for (int c = 0; c < N; c++) begin
      int gap;
      gap = (c > 1) ? c : 1;
      setCfg(c, c, 1'b0);
      logN = 0;
      post(c, 4);
      idle(4 * gap + 12);
      chk(logN == 4, "R2", logN, 4);
      for (int k = 0; k < 4; k++) chk(logId[k] == c, "R11", logId[k], c);
      for (int k = 1; k < 4; k++) chk(logCyc[k] - logCyc[k-1] == gap, "R4", logCyc[k] - logCyc[k-1], gap);
    end

    // R2: a drained connection is never offered again.
    logN = 0;
    idle(20);
    chk(logN == 0 && grantValid == 1'b0, "R2", logN, 0);

    // R2: posting during a drain adds to the remaining cells.
    setCfg(0, 2, 1'b0);
    logN = 0;
    post(0, 3);
    idle(2);
    post(0, 2);
    idle(25);
    chk(logN == 5, "R2", logN, 5);

    // R5: two different intervals drained together.
    setCfg(1, 2, 1'b0);
    setCfg(3, 3, 1'b0);
    idle(10);
    logN = 0;
    post(1, 3);
    post(3, 3);
    idle(30);
    cntA = 0; cntB = 0; lastA = -100; lastB = -100;
    for (int k = 0; k < logN; k++) begin
      if (logId[k] == 1) begin
        chk(logCyc[k] - lastA >= 2, "R5", logCyc[k] - lastA, 2);
        lastA = logCyc[k]; cntA++;
      end else begin
        chk(logId[k] == 3, "R5", logId[k], 3);
        chk(logCyc[k] - lastB >= 3, "R5", logCyc[k] - lastB, 3);
        lastB = logCyc[k]; cntB++;
      end
    end
    chk(cntA == 3, "R5", cntA, 3);
    chk(cntB == 3, "R5", cntB, 3);

    // R6: low-delay ignores a large interval.
    setCfg(4, 9, 1'b1);
    logN = 0;
    post(4, 3);
    idle(10);
    chk(logN == 3, "R6", logN, 3);
    for (int k = 1; k < 3; k++) chk(logCyc[k] - logCyc[k-1] == 1, "R6", logCyc[k] - logCyc[k-1], 1);

    // R3/R7: held grant survives a low-delay arrival, then low-delay overtakes.
    doReset();
    post(5, 2);
    setCfg(6, 0, 1'b1);
    post(6, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(grantValid == 1'b1, "R3", int'(grantValid), 1);
      chk(grantId == 3'd5, "R3", int'(grantId), 5);
    end
    chk(logN == 0, "R3", logN, 0);
    grantReady = 1'b1;
    idle(6);
    e = '{5, 6, 5, 0, 0, 0, 0, 0};
    expectIds("R7", 3, e);

    // R7: low-delay cells bypass an already draining paced connection.
    setCfg(7, 0, 1'b1);
    idle(3);
    grantReady = 1'b0;
    post(0, 4);
    post(7, 2);
    logN = 0;
    grantReady = 1'b1;
    idle(10);
    e = '{0, 7, 7, 0, 0, 0, 0, 0};
    expectIds("R7", 6, e);

    // R8: paced round-robin from reset starts after connection 0.
    doReset();
    post(1, 2);
    post(2, 2);
    post(3, 2);
    logN = 0;
    grantReady = 1'b1;
    idle(10);
    e = '{1, 2, 3, 1, 2, 3, 0, 0};
    expectIds("R8", 6, e);

    // R9: low-delay pointer is separate from the paced pointer.
    doReset();
    setCfg(0, 0, 1'b1);
    setCfg(2, 0, 1'b1);
    setCfg(6, 0, 1'b1);
    post(5, 1);
    post(6, 1);
    post(2, 1);
    post(0, 1);
    logN = 0;
    grantReady = 1'b1;
    idle(8);
    e = '{5, 2, 6, 0, 0, 0, 0, 0};
    expectIds("R9", 4, e);

    grantReady = 1'b0;
    post(2, 1);
    post(4, 1);
    post(1, 1);
    logN = 0;
    grantReady = 1'b1;
    idle(8);
    e = '{2, 1, 4, 0, 0, 0, 0, 0};
    expectIds("R9", 3, e);

    summary();
  end
endmodule